// File: doc/BRIEF.md
# Framed Serial Register Port for a Dual-Channel DAC

This block is the digital front end of a two-channel, 16-bit digital-to-analog converter. A host drives a three-wire serial link: a serial clock, an active-low frame select and a data line. Each frame carries a 24-bit word. The block decodes the word and writes it into a small bank of registers. Each channel has a staged input code, a live output code, a gain word and an offset word. The live output codes drive the converter cores, one 16-bit code per channel.

Frames are strict. A frame counts only if the data line was sampled exactly 24 times while the frame select was low. Nothing is written until the frame select rises again. A written code stays in the staging register until the load strobe moves every channel to its output at once. The clear strobe forces the outputs to the zero code. A coding pin chooses how a stored code maps onto the converter scale. A serial output lets a host read registers back and lets several blocks be chained on one link.

All serial pins are oversampled in the system clock domain. The load strobe, the clear strobe and the coding pin are synchronous inputs sampled on the system clock.

Top module: `serial_dac_port`

## Requirements
- R1: After reset, every input, output, gain and offset register holds 0x0000 and `sdo` is 0.
- R2: `dac_code` carries channel A in bits 15:0 and channel B in bits 31:16. When `bin_mode` is 1, each field equals the stored output code. When `bin_mode` is 0, bit 15 of each field is inverted, so a stored 0x0000 appears as 0x8000 (mid-scale).
- R3: Frame bits arrive MSB first, one bit per falling `sclk` edge while `sync_n` is low. Bit 23 is the read flag (1 = read). Bit 22 is unused on write. Bits 21:19 are the register select, bits 18:16 the channel address, and bits 15:0 the payload.
- R4: A frame with fewer or more than 24 falling `sclk` edges inside one `sync_n` low window changes no register.
- R5: A valid write frame updates the addressed register when `sync_n` rises. The output codes do not change until a load.
- R6: While `ldac_n` is low and `clr_n` is high, every channel's output register takes its input register value on the next clock.
- R7: While `clr_n` is low, every output register becomes 0x0000 on the next clock. This takes priority over `ldac_n`, and the input registers are kept.
- R8: Register select 000 picks the input code, 010 the gain and 011 the offset. Other selects are ignored. Channel address 000 picks A, 001 picks B and 100 writes both. Other addresses are ignored.
- R9: A valid read frame loads the shift register with the frame's top 8 bits followed by the selected register. The shift register then shifts out on `sdo`, MSB first, during the next frame. Address 100 reads channel A.
- R10: `sdo` shows the current top bit of the 24-bit shift register before each falling `sclk` edge. The 24 bits of any frame that is not a read therefore reappear on `sdo` during the following frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock, idle high |
| sync_n | input | 1 | Active-low frame select |
| sdin | input | 1 | Serial data in |
| ldac_n | input | 1 | Active-low load of all outputs from the input registers |
| clr_n | input | 1 | Active-low clear of all outputs to the zero code |
| bin_mode | input | 1 | 1: offset binary, 0: two's complement |
| sdo | output | 1 | Serial data out for readback and chaining |
| dac_code | output | 32 | Converter codes, channel A in the low half |

## Verification
A wrong bit counter or a wrong address decode leaves a staging register with the wrong value. This is invisible at `dac_code` until the next load strobe, which is why every write in the bench is followed by a load and a compare. A wrong gain or offset register shows only through readback, one full frame after the read request. A fault in the shift path appears on `sdo` within the following frame.

// File: rtl/sdp_pkg.sv
package sdp_pkg;
   localparam int HDR_W = 8;
   localparam logic [2:0] SEL_DATA   = 3'b000;
   localparam logic [2:0] SEL_GAIN   = 3'b010;
   localparam logic [2:0] SEL_OFFS   = 3'b011;
   localparam logic [2:0] ADDR_BCAST = 3'b100;
endpackage

// File: rtl/sdp_sync.sv
module sdp_sync #(
   parameter int         W       = 3,
   parameter int         STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] stg [STAGES];

   genvar g;
   generate
      for (g = 0; g < STAGES; g++) begin : g_stage
         if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stg[g] <= RST_VAL;
               else        stg[g] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stg[g] <= RST_VAL;
               else        stg[g] <= stg[g-1];
            end
         end
      end
   endgenerate

   assign q = stg[STAGES-1];
endmodule

// File: rtl/sdp_frame_rx.sv
module sdp_frame_rx #(
   parameter int FRAME_W = 24
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sclk_s,
   input  logic               sync_s,
   input  logic               sdin_s,
   input  logic               load_en,
   input  logic [FRAME_W-1:0] load_word,
   output logic               frame_ok,
   output logic [FRAME_W-1:0] word,
   output logic               sdo
);
   localparam int CNT_MAX = FRAME_W + 1;
   localparam int CNT_W   = $clog2(FRAME_W + 2);

   logic             sclk_p, sync_p;
   logic             sclk_fall, sync_fall, sync_rise, take_bit;
   logic [CNT_W-1:0] cnt;
   logic [FRAME_W-1:0] shreg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_p <= 1'b1;
         sync_p <= 1'b1;
      end else begin
         sclk_p <= sclk_s;
         sync_p <= sync_s;
      end
   end

   assign sclk_fall = sclk_p & ~sclk_s;
   assign sync_fall = sync_p & ~sync_s;
   assign sync_rise = ~sync_p & sync_s;
   assign take_bit  = sclk_fall & ~sync_s;

   // counter saturates one past the frame length so overlong frames stay rejected
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (sync_fall)
         cnt <= '0;
      else if (take_bit && cnt != CNT_W'(CNT_MAX))
         cnt <= cnt + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         shreg <= '0;
      else if (load_en)
         shreg <= load_word;
      else if (take_bit)
         shreg <= {shreg[FRAME_W-2:0], sdin_s};
   end

   assign frame_ok = sync_rise && (cnt == CNT_W'(FRAME_W));
   assign word     = shreg;
   assign sdo      = shreg[FRAME_W-1];
endmodule

// File: rtl/sdp_reg_bank.sv
module sdp_reg_bank
   import sdp_pkg::*;
#(
   parameter int DATA_W  = 16,
   parameter int NUM_CH  = 2,
   parameter int FRAME_W = 24
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     frame_ok,
   input  logic [FRAME_W-1:0]       word,
   input  logic                     ldac_n,
   input  logic                     clr_n,
   input  logic                     bin_mode,
   output logic                     rd_load,
   output logic [FRAME_W-1:0]       rd_word,
   output logic [NUM_CH*DATA_W-1:0] in_flat,
   output logic [NUM_CH*DATA_W-1:0] out_flat,
   output logic [NUM_CH*DATA_W-1:0] dac_code
);
   localparam logic [DATA_W-1:0] MID_FLIP = {1'b1, {(DATA_W-1){1'b0}}};

   logic              rd;
   logic [2:0]        sel, addr;
   logic [DATA_W-1:0] pay, rd_val;

   logic [DATA_W-1:0] in_a   [NUM_CH];
   logic [DATA_W-1:0] gain_a [NUM_CH];
   logic [DATA_W-1:0] ofs_a  [NUM_CH];

   assign rd   = word[FRAME_W-1];
   assign sel  = word[DATA_W+5:DATA_W+3];
   assign addr = word[DATA_W+2:DATA_W];
   assign pay  = word[DATA_W-1:0];

   genvar ch;
   generate
      for (ch = 0; ch < NUM_CH; ch++) begin : g_ch
         logic              hit, wr;
         logic [DATA_W-1:0] in_q, gain_q, ofs_q, out_q;

         assign hit = (addr == 3'(ch)) || (addr == ADDR_BCAST);
         assign wr  = frame_ok && !rd && hit;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               in_q   <= '0;
               gain_q <= '0;
               ofs_q  <= '0;
            end else if (wr) begin
               if (sel == SEL_DATA) in_q   <= pay;
               if (sel == SEL_GAIN) gain_q <= pay;
               if (sel == SEL_OFFS) ofs_q  <= pay;
            end
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               out_q <= '0;
            else if (!clr_n)
               out_q <= '0;
            else if (!ldac_n)
               out_q <= in_q;
         end

         assign in_a[ch]   = in_q;
         assign gain_a[ch] = gain_q;
         assign ofs_a[ch]  = ofs_q;
         assign in_flat[ch*DATA_W +: DATA_W]  = in_q;
         assign out_flat[ch*DATA_W +: DATA_W] = out_q;
         assign dac_code[ch*DATA_W +: DATA_W] = bin_mode ? out_q : (out_q ^ MID_FLIP);
      end
   endgenerate

   always_comb begin
      rd_val = '0;
      for (int c = 0; c < NUM_CH; c++) begin
         if ((addr == 3'(c)) || (addr == ADDR_BCAST && c == 0)) begin
            case (sel)
               SEL_DATA: rd_val = in_a[c];
               SEL_GAIN: rd_val = gain_a[c];
               SEL_OFFS: rd_val = ofs_a[c];
               default:  rd_val = '0;
            endcase
         end
      end
   end

   assign rd_load = frame_ok && rd;
   assign rd_word = {word[FRAME_W-1 -: HDR_W], rd_val};
endmodule

// File: rtl/serial_dac_port.sv
module serial_dac_port #(
   parameter int DATA_W      = 16,
   parameter int NUM_CH      = 2,
   parameter int FRAME_W     = 24,
   parameter int SYNC_STAGES = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     sclk,
   input  logic                     sync_n,
   input  logic                     sdin,
   input  logic                     ldac_n,
   input  logic                     clr_n,
   input  logic                     bin_mode,
   output logic                     sdo,
   output logic [NUM_CH*DATA_W-1:0] dac_code
);
   generate
      if (FRAME_W != DATA_W + sdp_pkg::HDR_W) begin : g_bad_frame
         $error("FRAME_W must equal DATA_W plus the 8-bit header");
      end
      if (NUM_CH < 1 || NUM_CH > 4) begin : g_bad_ch
         $error("NUM_CH must be between 1 and 4");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [2:0]               pins_s;
   logic                     frame_ok, rd_load;
   logic [FRAME_W-1:0]       word, rd_word;
   logic [NUM_CH*DATA_W-1:0] in_flat, out_flat;

   sdp_sync #(
      .W       (3),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (3'b011)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({sdin, sync_n, sclk}),
      .q     (pins_s)
   );

   sdp_frame_rx #(
      .FRAME_W (FRAME_W)
   ) u_rx (
      .clk       (clk),
      .rst_n     (rst_n),
      .sclk_s    (pins_s[0]),
      .sync_s    (pins_s[1]),
      .sdin_s    (pins_s[2]),
      .load_en   (rd_load),
      .load_word (rd_word),
      .frame_ok  (frame_ok),
      .word      (word),
      .sdo       (sdo)
   );

   sdp_reg_bank #(
      .DATA_W  (DATA_W),
      .NUM_CH  (NUM_CH),
      .FRAME_W (FRAME_W)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .frame_ok (frame_ok),
      .word     (word),
      .ldac_n   (ldac_n),
      .clr_n    (clr_n),
      .bin_mode (bin_mode),
      .rd_load  (rd_load),
      .rd_word  (rd_word),
      .in_flat  (in_flat),
      .out_flat (out_flat),
      .dac_code (dac_code)
   );
endmodule

// File: rtl/serial_dac_port_chk.sv
module serial_dac_port_chk #(
   parameter int DATA_W = 16,
   parameter int NUM_CH = 2
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     ldac_n,
   input logic                     clr_n,
   input logic                     frame_ok,
   input logic [NUM_CH*DATA_W-1:0] in_flat,
   input logic [NUM_CH*DATA_W-1:0] out_flat
);
   // R7
   clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_n |=> (out_flat == '0));

   // R6
   load_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_n && !ldac_n) |=> (out_flat == $past(in_flat)));

   // R5
   out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_n && ldac_n) |=> $stable(out_flat));

   // R4
   stage_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_ok |=> $stable(in_flat));
endmodule

bind serial_dac_port serial_dac_port_chk #(
   .DATA_W (DATA_W),
   .NUM_CH (NUM_CH)
) chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .ldac_n   (ldac_n),
   .clr_n    (clr_n),
   .frame_ok (frame_ok),
   .in_flat  (in_flat),
   .out_flat (out_flat)
);

// File: tb/serial_dac_port_test.sv
module serial_dac_port_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sclk = 1'b1;
   logic        sync_n = 1'b1;
   logic        sdin = 1'b0;
   logic        ldac_n = 1'b1;
   logic        clr_n = 1'b1;
   logic        bin_mode = 1'b1;
   logic        sdo;
   logic [31:0] dac_code;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;

   always #4 clk = ~clk;

   serial_dac_port uut (
      .clk      (clk),
      .rst_n    (rst_n),
      .sclk     (sclk),
      .sync_n   (sync_n),
      .sdin     (sdin),
      .ldac_n   (ldac_n),
      .clr_n    (clr_n),
      .bin_mode (bin_mode),
      .sdo      (sdo),
      .dac_code (dac_code)
   );

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc == 150000) begin
         fails = fails + 1;
         $display("FAIL watchdog (all requirements): actual cycle %0d expected completion", cyc);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   // frame, expected channel B code, expected channel A code (bin_mode = 1)
   localparam logic [55:0] VEC [8] = '{
      {24'h001234, 16'h0000, 16'h1234},  // R3 R8 write A
      {24'h01BEEF, 16'hBEEF, 16'h1234},  // R8 write B
      {24'h045555, 16'h5555, 16'h5555},  // R8 broadcast
      {24'h10AAAA, 16'h5555, 16'h5555},  // R8 gain A, outputs untouched
      {24'h02FFFF, 16'h5555, 16'h5555},  // R8 bad address ignored
      {24'h08FFFF, 16'h5555, 16'h5555},  // R8 bad select ignored
      {24'h00FFFF, 16'h5555, 16'hFFFF},  // R3 write A
      {24'h410F0F, 16'h0F0F, 16'hFFFF}   // R3 spare bit ignored
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks = checks + 1;
      if (act !== exp) begin
         fails = fails + 1;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic send(input logic [23:0] f, input int n, output logic [23:0] cap);
      cap = '0;
      sync_n = 1'b0;
      wait_clk(4);
      for (int i = 0; i < n; i++) begin
         sdin = (i < 24) ? f[23-i] : 1'b0;
         wait_clk(4);
         cap = {cap[22:0], sdo};
         sclk = 1'b0;
         wait_clk(4);
         sclk = 1'b1;
      end
      wait_clk(4);
      sync_n = 1'b1;
      wait_clk(8);
   endtask

   task automatic pulse_ldac();
      ldac_n = 1'b0;
      wait_clk(2);
      ldac_n = 1'b1;
      wait_clk(2);
   endtask

   initial begin
      logic [23:0] cap;
      wait_clk(5);
      rst_n = 1'b1;
      wait_clk(3);
      // R1 reset state
      check("R1 reset code", dac_code, 32'h0000_0000);
      check("R1 reset sdo", {31'b0, sdo}, 32'h0);
      // R2 coding select
      bin_mode = 1'b0;
      wait_clk(1);
      check("R2 twos-comp zero is mid-scale", dac_code, 32'h8000_8000);
      bin_mode = 1'b1;
      wait_clk(1);

      // R5 staging: write is invisible until load
      send(24'h001234, 24, cap);
      check("R5 output held before load", dac_code, 32'h0000_0000);

      for (int v = 0; v < 8; v++) begin
         send(VEC[v][55:32], 24, cap);
         pulse_ldac();
         check("R3/R6/R8 vector", dac_code, VEC[v][31:0]);
      end

      // R4 short and long frames discarded
      send(24'h000000, 23, cap);
      send(24'h000000, 25, cap);
      pulse_ldac();
      check("R4 bad-length frames", dac_code, 32'h0F0F_FFFF);
      send(24'h800000, 24, cap);
      send(24'h020000, 24, cap);
      check("R4 R9 readback A after bad frames", {8'h0, cap}, 32'h0080_FFFF);

      // R9 readback of gain A, R10 chaining
      send(24'h900000, 24, cap);
      send(24'h020000, 24, cap);
      check("R9 gain A readback", {8'h0, cap}, 32'h0090_AAAA);
      send(24'h020000, 24, cap);
      check("R10 previous frame on sdo", {8'h0, cap}, 32'h0002_0000);
      send(24'h191357, 24, cap);
      send(24'h990000, 24, cap);
      send(24'h020000, 24, cap);
      check("R9 offset B readback", {8'h0, cap}, 32'h0099_1357);
      send(24'h810000, 24, cap);
      send(24'h020000, 24, cap);
      check("R9 data B readback", {8'h0, cap}, 32'h0081_0F0F);

      // R7 clear, priority, input kept
      clr_n = 1'b0;
      wait_clk(2);
      clr_n = 1'b1;
      wait_clk(2);
      check("R7 clear to zero", dac_code, 32'h0000_0000);
      pulse_ldac();
      check("R7 inputs kept through clear", dac_code, 32'h0F0F_FFFF);
      clr_n = 1'b0;
      ldac_n = 1'b0;
      wait_clk(2);
      check("R7 clear beats load", dac_code, 32'h0000_0000);
      clr_n = 1'b1;
      wait_clk(2);
      ldac_n = 1'b1;
      wait_clk(1);
      check("R6 load after clear", dac_code, 32'h0F0F_FFFF);

      // R2 coding on live values
      bin_mode = 1'b0;
      wait_clk(1);
      check("R2 twos-comp mapping", dac_code, 32'h8F0F_7FFF);
      bin_mode = 1'b1;

      // R1 reset with clear held low
      clr_n = 1'b0;
      rst_n = 1'b0;
      wait_clk(3);
      rst_n = 1'b1;
      wait_clk(3);
      clr_n = 1'b1;
      wait_clk(1);
      check("R1 zero after reset with clear", dac_code, 32'h0000_0000);
      pulse_ldac();
      check("R1 inputs zero after reset", dac_code, 32'h0000_0000);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule